// File: doc/BRIEF.md
# ROM-Driven Dial Sequence Controller

This block plays back a fixed list of dial codes held in an on-chip read-only table. While idle, its address counter is parked at address 0. Pulling the active-low trigger input low lets the counter run. The counter then steps one address per step tick, and the step tick comes from an internal prescaler. Each step presents the next stored word.

The least significant bit of every stored word is a hold-on flag. The word at address 0 has this flag clear, so a run lasts only while the trigger is held, up to the first step. Every later word of a sequence has the flag set, so once the counter has left address 0 the run carries on by itself, even if the trigger is released. A word with the flag clear at a nonzero address ends the run and sends the counter back to address 0.

The upper seven bits of each word go to a downstream tone encoder, together with a one-cycle valid strobe.

Top module: `dial_seq_player`

## Requirements
- R1: After synchronous reset `busy` and `code_valid` are 0 and the word at address 0 is presented, so `code` shows bits 7:1 of that word.
- R2: The trigger passes through a two-stage synchroniser. If `trig_n` is low at two consecutive rising edges, `busy` is 1 after the second of those edges and still 0 after the first.
- R3: While running, the address advances by exactly one every `STEP_DIV` clock cycles. Consecutive `code_valid` pulses within one run are exactly `STEP_DIV` cycles apart.
- R4: Bit 0 of the word at address 0 is 0. If the trigger is released before the first step, the block returns to standby and produces no `code_valid` pulse.
- R5: Once the address has left 0, the run continues with the trigger released. It emits the codes of words 1, 2, … in address order until the terminating word.
- R6: A word at a nonzero address whose bit 0 is 0 (normally 8'hFE) ends the run. `busy` falls while that word is addressed, the counter returns to 0, and no code is emitted for it. A run whose terminator sits at address N keeps `busy` high for exactly N×`STEP_DIV` cycles. Words stored beyond the terminator are never reached.
- R7: `code` equals bits 7:1 of the addressed word. `code_valid` is a one-cycle pulse in the cycle after each step onto a word whose bit 0 is 1.
- R8: The trigger is a level. If it is held low through a terminator, a new run starts from address 0, with `busy` low for exactly one cycle between the runs.
- R9: `busy` is 1 exactly when the counter is not being forced to address 0, and `code_valid` is never 1 while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_n | input | 1 | Asynchronous start request, active low, level sensitive |
| code | output | 7 | Bits 7:1 of the currently addressed word |
| code_valid | output | 1 | One-cycle strobe marking a new code |
| busy | output | 1 | High while a sequence is running |

## Verification
On every cycle, the assertions check the following:
- the address either holds, moves up by one on a tick, or returns to zero when the run stops;
- tick and valid pulses never last two cycles;
- valid never appears while idle;
- a run only begins from a synchronised trigger.

Only the bench scenarios can show the end-to-end behaviour:
- the code order;
- the exact run length for a given terminator position;
- that a short trigger pulse aborts at address 0;
- the one-cycle gap when the trigger is held through a terminator.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
  localparam int WORD_W     = 8;
  localparam int CODE_W     = WORD_W - 1;
  localparam int DEF_ADDR_W = 5;
  localparam int DEF_DEPTH  = 1 << DEF_ADDR_W;

  // Default table: idle word, seven dial codes, terminator, zero fill.
  function automatic logic [DEF_DEPTH*WORD_W-1:0] default_image();
    logic [DEF_DEPTH*WORD_W-1:0] img;
    img = '0;
    for (int i = 1; i <= 7; i++) begin
      img[i*WORD_W +: WORD_W] = {CODE_W'(i * 9 + 16), 1'b1};
    end
    img[8*WORD_W +: WORD_W] = 8'hFE;
    return img;
  endfunction

  // Run condition: trigger level or the stored hold-on flag.
  function automatic logic keep_running(logic trig_lo, logic [WORD_W-1:0] w);
    return trig_lo | w[0];
  endfunction

  // A clear hold-on flag away from the origin marks the end of a sequence.
  function automatic logic end_of_seq(logic at_origin, logic [WORD_W-1:0] w);
    return !at_origin && !w[0];
  endfunction

  function automatic logic [CODE_W-1:0] code_of(logic [WORD_W-1:0] w);
    return w[WORD_W-1:1];
  endfunction
endpackage

// File: rtl/dsp_trig_sync.sv
module dsp_trig_sync (
  input  logic clk,
  input  logic rst,
  input  logic trig_n_i,
  output logic trig_lo_o
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= 1'b1;
      stage2_q <= 1'b1;
    end else begin
      stage1_q <= trig_n_i;
      stage2_q <= stage1_q;
    end
  end

  assign trig_lo_o = !stage2_q;
endmodule

// File: rtl/dsp_step_prescaler.sv
module dsp_step_prescaler #(
  parameter int STEP_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_i,
  output logic tick_o
);
  localparam int CNT_W = (STEP_DIV > 2) ? $clog2(STEP_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_DIV - 1);
  localparam logic [CNT_W-1:0] INC  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || hold_i) begin
      cnt_q <= '0;
    end else if (tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + INC;
    end
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o); // R3
endmodule

// File: rtl/dsp_seq_rom.sv
module dsp_seq_rom #(
  parameter int ADDR_W = dsp_pkg::DEF_ADDR_W,
  parameter logic [(1<<ADDR_W)*dsp_pkg::WORD_W-1:0] IMAGE = '0
) (
  input  logic [ADDR_W-1:0]          addr_i,
  output logic [dsp_pkg::WORD_W-1:0] word_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [dsp_pkg::WORD_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    assign mem[g] = IMAGE[g*dsp_pkg::WORD_W +: dsp_pkg::WORD_W];
  end

  assign word_o = mem[addr_i];
endmodule

// File: rtl/dial_seq_player.sv
module dial_seq_player #(
  parameter int ADDR_W   = dsp_pkg::DEF_ADDR_W,
  // Clock cycles per step; 25e6 gives two steps per second at 50 MHz.
  parameter int STEP_DIV = 25_000_000,
  parameter logic [(1<<ADDR_W)*dsp_pkg::WORD_W-1:0] ROM_IMAGE = dsp_pkg::default_image()
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       trig_n,
  output logic [dsp_pkg::CODE_W-1:0] code,
  output logic                       code_valid,
  output logic                       busy
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic                       trig_lo;
  logic [dsp_pkg::WORD_W-1:0] word;
  logic                       step_tick;
  logic [ADDR_W-1:0]          addr_q;
  logic                       step_q;
  logic                       at_origin;
  logic                       run;
  logic                       end_hit;
  logic                       park;

  dsp_trig_sync u_sync (
    .clk      (clk),
    .rst      (rst),
    .trig_n_i (trig_n),
    .trig_lo_o(trig_lo)
  );

  dsp_seq_rom #(.ADDR_W(ADDR_W), .IMAGE(ROM_IMAGE)) u_rom (
    .addr_i(addr_q),
    .word_o(word)
  );

  dsp_step_prescaler #(.STEP_DIV(STEP_DIV)) u_pre (
    .clk   (clk),
    .rst   (rst),
    .hold_i(park),
    .tick_o(step_tick)
  );

  assign at_origin = (addr_q == '0);
  assign run       = dsp_pkg::keep_running(trig_lo, word);
  assign end_hit   = dsp_pkg::end_of_seq(at_origin, word);
  assign park      = !run || end_hit;

  always_ff @(posedge clk) begin
    if (rst || park) begin
      addr_q <= '0;
      step_q <= 1'b0;
    end else begin
      step_q <= step_tick;
      if (step_tick) begin
        addr_q <= addr_q + ONE;
      end
    end
  end

  assign code       = dsp_pkg::code_of(word);
  assign code_valid = step_q && word[0];
  assign busy       = !park;

  AST_PARK_HOMES: assert property (@(posedge clk) disable iff (rst)
    park |=> (addr_q == '0)); // R6
  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (rst)
    (!park && !step_tick) |=> $stable(addr_q)); // R3
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    (!park && step_tick) |=> (addr_q == $past(addr_q) + ONE)); // R3
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    code_valid |=> !code_valid); // R7
  AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !code_valid); // R9
  AST_START_NEEDS_TRIGGER: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> trig_lo); // R2
endmodule

// File: tb/tb_dial_seq_player.sv
module tb_dial_seq_player;
  localparam int AW      = 4;
  localparam int DIV     = 4;
  localparam int SEQ_END = 10;
  localparam int NCODES  = 9;
  localparam logic [6:0] CODES [NCODES] =
    '{7'h31, 7'h32, 7'h33, 7'h2A, 7'h23, 7'h30, 7'h39, 7'h05, 7'h7F};

  // Idle word, nine codes, terminator at SEQ_END, then words with bit 0 set.
  function automatic logic [(1<<AW)*8-1:0] build_image();
    logic [(1<<AW)*8-1:0] img;
    img = '1;
    img[7:0] = 8'h00;
    for (int i = 1; i <= NCODES; i++) img[i*8 +: 8] = {CODES[i-1], 1'b1};
    img[SEQ_END*8 +: 8] = 8'hFE;
    return img;
  endfunction

  logic       clk = 1'b0;
  logic       rst;
  logic       trig_n;
  logic [6:0] code;
  logic       code_valid;
  logic       busy;

  dial_seq_player #(.ADDR_W(AW), .STEP_DIV(DIV), .ROM_IMAGE(build_image())) dut (
    .clk(clk), .rst(rst), .trig_n(trig_n),
    .code(code), .code_valid(code_valid), .busy(busy)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [6:0] exp_q [$];
  int valid_seen = 0, pops = 0, runs = 0;
  int cyc = 0, cur_len = 0, last_len = 0, gap = 0, last_gap = 0;
  int prev_vcyc = 0;
  bit have_prev = 0, prev_busy = 0, done = 0;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_seq();
    for (int i = 0; i < NCODES; i++) exp_q.push_back(CODES[i]);
  endtask

  task automatic wait_runs(int target);
    for (int i = 0; i < 2000 && runs < target; i++) @(negedge clk);
    check(runs >= target, "R5 run completion", runs, target);
  endtask

  // Monitor: scoreboard pop, step spacing, busy run and gap lengths.
  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (busy) cur_len++;
      else gap++;
      if (!busy && prev_busy) begin
        last_len = cur_len; cur_len = 0; runs++; gap = 1;
      end
      if (busy && !prev_busy) last_gap = gap;
      if (code_valid) begin
        valid_seen++;
        if (exp_q.size() == 0) begin
          check(0, "R7 unexpected code_valid", int'(code), -1);
        end else begin
          logic [6:0] e;
          e = exp_q.pop_front();
          pops++;
          check(code == e, "R7 code value", int'(code), int'(e));
        end
        if (have_prev) check(cyc - prev_vcyc == DIV, "R3 valid spacing", cyc - prev_vcyc, DIV);
        prev_vcyc = cyc; have_prev = 1;
      end
      if (!busy) have_prev = 0;
      prev_busy = busy;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R5 watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int runs0, pops0;
    rst = 1'b1; trig_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b0, "R1 busy after reset", busy, 0);
    check(code_valid == 1'b0, "R1 valid after reset", code_valid, 0);
    check(code == 7'h00, "R1 code of word 0", int'(code), 0);

    // R2 latency, then release early: R4 abort at address 0.
    trig_n = 1'b0;
    @(posedge clk); @(negedge clk);
    check(busy == 1'b0, "R2 busy after first edge", busy, 0);
    @(posedge clk); @(negedge clk);
    check(busy == 1'b1, "R2 busy after second edge", busy, 1);
    trig_n = 1'b1;
    repeat (20) @(negedge clk);
    check(busy == 1'b0, "R4 standby after short trigger", busy, 0);
    check(valid_seen == 0, "R4 no code on short trigger", valid_seen, 0);

    // R5/R6: trigger released after leaving address 0.
    runs0 = runs; pops0 = pops;
    push_seq();
    trig_n = 1'b0;
    repeat (8) @(negedge clk);
    trig_n = 1'b1;
    wait_runs(runs0 + 1);
    check(last_len == SEQ_END * DIV, "R6 run length", last_len, SEQ_END * DIV);
    repeat (12) @(negedge clk);
    check(busy == 1'b0, "R6 stays in standby past terminator", busy, 0);
    check(pops - pops0 == NCODES, "R5 codes emitted", pops - pops0, NCODES);
    check(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);

    // R8: held low through the terminator restarts the sequence.
    runs0 = runs; pops0 = pops;
    push_seq(); push_seq();
    trig_n = 1'b0;
    wait_runs(runs0 + 1);
    check(last_len == SEQ_END * DIV, "R8 first held run length", last_len, SEQ_END * DIV);
    @(negedge clk);
    check(busy == 1'b1, "R8 restart after one idle cycle", busy, 1);
    check(last_gap == 1, "R8 idle gap", last_gap, 1);
    wait_runs(runs0 + 2);
    check(last_len == SEQ_END * DIV, "R8 second held run length", last_len, SEQ_END * DIV);
    trig_n = 1'b1;
    repeat (20) @(negedge clk);
    check(busy == 1'b0, "R9 idle after release", busy, 0);
    check(pops - pops0 == 2 * NCODES, "R8 codes over two runs", pops - pops0, 2 * NCODES);
    check(exp_q.size() == 0, "R8 scoreboard drained", exp_q.size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule